// File: doc/BRIEF.md
# Split Page Translation Cache

This block keeps recently used virtual-to-physical translations for 4 KB pages so that most accesses avoid a page-table walk. It holds two separate structures: one serves instruction fetches and the other serves every data-side access kind. Each structure is two-way set-associative. Every entry carries its own most-recent marker and invalid marker.

A caller presents a lookup with a virtual address and an access kind. One cycle later it receives a registered hit flag and the physical address. When the lookup misses, the caller walks the page table on its own. It then installs the result with a fill, which carries the second word of the page-table entry. An invalidate command names a set index and drops that set in both structures. A write that hits a page whose changed bit is still clear is reported as a miss on purpose, so that the walker also marks the page changed in memory. Probe lookups observe the cache without disturbing it.

Top module: `xlat_buffer`

## Requirements
- R1: Each of the two structures holds 64 sets of 2 ways. The set index is virtual address bits [17:12]. The stored tag is virtual address bits [31:12], so two pages that share a set but differ in upper bits do not alias.
- R2: A lookup presented in one cycle produces res_valid, res_hit and res_pa on the following cycle. On a hit, res_pa is the entry word's bits [31:12] followed by the virtual address bits [11:0]. On a miss, res_pa is zero.
- R3: Access kinds are encoded as 0 read, 1 write, 2 fetch and 3 probe. Kind 2 uses the instruction structure and the other kinds use the data structure, for both lookups and fills.
- R4: An entry hits only when its tag matches and its invalid marker is clear.
- R5: A write lookup that hits an entry whose changed bit (entry-word bit 7) is 0 reports a miss and sets that bit in the cached copy, so the next write to the page hits. Such a lookup leaves the most-recent markers unchanged.
- R6: A read, fetch, or write hit that reports a hit marks the hit way most-recent and clears the marker of the other way in that set.
- R7: A probe hit reports a hit and leaves both most-recent markers of the set unchanged.
- R8: A fill writes way 0 when way 0 is not most-recent or is invalid, and writes way 1 otherwise. The written way becomes valid and most-recent, holding the tag and the whole entry word, and the other way loses its marker.
- R9: A fill of kind 3 (probe) changes neither structure.
- R10: An invalidate marks both ways of the named set invalid in both structures, whatever their tags.
- R11: After reset every entry in both structures is invalid with zero tag and zero entry word, and res_valid, res_hit and res_pa are 0.
- R12: A lookup sees the state from before any fill or invalidate issued in the same cycle. Those commands apply after the lookup's own update. When a fill and an invalidate hit the same set in one cycle, the invalidate wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_kind | input | 2 | Lookup access kind (0 read, 1 write, 2 fetch, 3 probe) |
| lk_va | input | 32 | Lookup virtual address |
| fl_valid | input | 1 | Fill request this cycle |
| fl_kind | input | 2 | Fill access kind, same encoding |
| fl_vpn | input | 20 | Virtual page number (address bits 31:12) being filled |
| fl_pte | input | 32 | Second page-table entry word to store |
| inv_valid | input | 1 | Invalidate request this cycle |
| inv_set | input | 6 | Set index (address bits 17:12) to invalidate |
| res_valid | output | 1 | Registered: a lookup result is present |
| res_hit | output | 1 | Registered: the lookup hit |
| res_pa | output | 32 | Registered physical address, zero on a miss |

## Verification
The hardest state to reach is one in which the replacement choice depends on history. Hitting the set gives no sign of which way is most-recent, so that way can only be inferred through a later fill that evicts one of two resident pages. The stimulus loads two pages into one set, then touches one of them with either a normal hit or a probe. A third fill follows, and the test checks which of the original pages survives. The cycle-overlap cases are built the same way: a lookup paired in one cycle with an invalidate or a fill on the same set, followed by a lookup that shows the late effect.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_PROBE = 2'd3
    } kind_e;

    localparam int unsigned NUM_WAYS   = 2;
    localparam int unsigned NUM_ARRAYS = 2;
    localparam int unsigned ARR_DATA   = 0;
    localparam int unsigned ARR_INSTR  = 1;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int unsigned TAG_W = 20
) (
    input  logic [TAG_W-1:0] tag_in,
    input  logic [TAG_W-1:0] tag_w0,
    input  logic [TAG_W-1:0] tag_w1,
    input  logic             inv_w0,
    input  logic             inv_w1,
    output logic             hit_w0,
    output logic             hit_w1
);
    always_comb begin
        hit_w0 = !inv_w0 && (tag_w0 == tag_in);
        hit_w1 = !inv_w1 && (tag_w1 == tag_in);
    end
endmodule

// File: rtl/xlat_array.sv
module xlat_array
    import xlat_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PTE_W   = 32,
    parameter int unsigned PAGE_W  = 12,
    parameter int unsigned SET_W   = 6,
    parameter int unsigned CHG_BIT = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_en,
    input  kind_e                   lk_kind,
    input  logic [VA_W-1:0]         lk_va,
    input  logic                    fl_en,
    input  logic [VA_W-PAGE_W-1:0]  fl_vpn,
    input  logic [PTE_W-1:0]        fl_pte,
    input  logic                    inv_en,
    input  logic [SET_W-1:0]        inv_set,
    output logic                    hit_o,
    output logic [PTE_W-1:0]        pa_o
);
    localparam int unsigned SETS  = 1 << SET_W;
    localparam int unsigned TAG_W = VA_W - PAGE_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PTE_W-1:0] pte;
        logic             mru;
        logic             inv;
    } entry_t;

    entry_t ent_q [SETS][NUM_WAYS];
    entry_t ent_d [SETS][NUM_WAYS];

    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [SET_W-1:0] fl_set;
    logic             hit0, hit1, any_hit, hw, fw, need_chg;
    entry_t           sel;

    assign lk_set = lk_va[PAGE_W +: SET_W];
    assign lk_tag = lk_va[VA_W-1:PAGE_W];
    assign fl_set = fl_vpn[SET_W-1:0];

    xlat_match #(.TAG_W(TAG_W)) u_match (
        .tag_in (lk_tag),
        .tag_w0 (ent_q[lk_set][0].tag),
        .tag_w1 (ent_q[lk_set][1].tag),
        .inv_w0 (ent_q[lk_set][0].inv),
        .inv_w1 (ent_q[lk_set][1].inv),
        .hit_w0 (hit0),
        .hit_w1 (hit1)
    );

    always_comb begin
        ent_d    = ent_q;
        any_hit  = hit0 || hit1;
        hw       = hit0 ? 1'b0 : 1'b1;
        sel      = ent_q[lk_set][hw];
        need_chg = (lk_kind == KIND_WRITE) && !sel.pte[CHG_BIT];
        hit_o    = lk_en && any_hit && !need_chg;
        pa_o     = {sel.pte[PTE_W-1:PAGE_W], lk_va[PAGE_W-1:0]};

        // lookup effect first
        if (lk_en && any_hit) begin
            if (need_chg) begin
                ent_d[lk_set][hw].pte[CHG_BIT] = 1'b1;
            end else if (lk_kind != KIND_PROBE) begin
                ent_d[lk_set][hw].mru  = 1'b1;
                ent_d[lk_set][~hw].mru = 1'b0;
            end
        end

        // fill sees the post-lookup markers
        fw = (!ent_d[fl_set][0].mru || ent_d[fl_set][0].inv) ? 1'b0 : 1'b1;
        if (fl_en) begin
            ent_d[fl_set][fw].tag  = fl_vpn;
            ent_d[fl_set][fw].pte  = fl_pte;
            ent_d[fl_set][fw].mru  = 1'b1;
            ent_d[fl_set][fw].inv  = 1'b0;
            ent_d[fl_set][~fw].mru = 1'b0;
        end

        // invalidate last, so it wins over a fill
        if (inv_en) begin
            ent_d[inv_set][0].inv = 1'b1;
            ent_d[inv_set][1].inv = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    ent_q[s][w] <= '{tag: '0, pte: '0, mru: 1'b0, inv: 1'b1};
                end
            end
        end else begin
            ent_q <= ent_d;
        end
    end

    // ---- checker state for the assertions below ----
    logic             chk_hit_q, chk_probe_q, chk_fill_q, chk_inv_q;
    logic [SET_W-1:0] chk_set_q, chk_fset_q, chk_iset_q;
    logic             chk_way_q, chk_fway_q, chk_m0_q, chk_m1_q;
    logic [TAG_W-1:0] chk_ftag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_hit_q   <= 1'b0;
            chk_probe_q <= 1'b0;
            chk_fill_q  <= 1'b0;
            chk_inv_q   <= 1'b0;
            chk_set_q   <= '0;
            chk_fset_q  <= '0;
            chk_iset_q  <= '0;
            chk_way_q   <= 1'b0;
            chk_fway_q  <= 1'b0;
            chk_m0_q    <= 1'b0;
            chk_m1_q    <= 1'b0;
            chk_ftag_q  <= '0;
        end else begin
            chk_hit_q   <= lk_en && any_hit && !need_chg && (lk_kind != KIND_PROBE)
                           && !fl_en && !inv_en;
            chk_probe_q <= lk_en && (lk_kind == KIND_PROBE) && !fl_en && !inv_en;
            chk_fill_q  <= fl_en && !(inv_en && (inv_set == fl_set));
            chk_inv_q   <= inv_en;
            chk_set_q   <= lk_set;
            chk_way_q   <= hw;
            chk_m0_q    <= ent_q[lk_set][0].mru;
            chk_m1_q    <= ent_q[lk_set][1].mru;
            chk_fset_q  <= fl_set;
            chk_fway_q  <= fw;
            chk_ftag_q  <= fl_vpn;
            chk_iset_q  <= inv_set;
        end
    end

    assert_mru_follows_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hit_q |-> (ent_q[chk_set_q][chk_way_q].mru && !ent_q[chk_set_q][~chk_way_q].mru));

    assert_single_mru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |-> !(ent_q[lk_set][0].mru && ent_q[lk_set][1].mru));

    assert_probe_keeps_markers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_probe_q |-> (ent_q[chk_set_q][0].mru == chk_m0_q && ent_q[chk_set_q][1].mru == chk_m1_q));

    assert_fill_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fill_q |-> (!ent_q[chk_fset_q][chk_fway_q].inv && ent_q[chk_fset_q][chk_fway_q].mru
                        && ent_q[chk_fset_q][chk_fway_q].tag == chk_ftag_q));

    assert_inval_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_inv_q |-> (ent_q[chk_iset_q][0].inv && ent_q[chk_iset_q][1].inv));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PTE_W   = 32,
    parameter int unsigned PAGE_W  = 12,
    parameter int unsigned SET_W   = 6,
    parameter int unsigned CHG_BIT = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [1:0]             lk_kind,
    input  logic [VA_W-1:0]        lk_va,
    input  logic                   fl_valid,
    input  logic [1:0]             fl_kind,
    input  logic [VA_W-PAGE_W-1:0] fl_vpn,
    input  logic [PTE_W-1:0]       fl_pte,
    input  logic                   inv_valid,
    input  logic [SET_W-1:0]       inv_set,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [PTE_W-1:0]       res_pa
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [PTE_W-1:0] pa;
    } result_t;

    result_t res_d, res_q;

    kind_e            lk_k, fl_k;
    logic             arr_hit [NUM_ARRAYS];
    logic [PTE_W-1:0] arr_pa  [NUM_ARRAYS];

    assign lk_k = kind_e'(lk_kind);
    assign fl_k = kind_e'(fl_kind);

    for (genvar a = 0; a < NUM_ARRAYS; a++) begin : g_arr
        localparam bit IS_INSTR = (a == ARR_INSTR);
        logic lk_en_a, fl_en_a;
        assign lk_en_a = lk_valid && ((lk_k == KIND_FETCH) == IS_INSTR);
        assign fl_en_a = fl_valid && (fl_k != KIND_PROBE) && ((fl_k == KIND_FETCH) == IS_INSTR);

        xlat_array #(
            .VA_W(VA_W), .PTE_W(PTE_W), .PAGE_W(PAGE_W),
            .SET_W(SET_W), .CHG_BIT(CHG_BIT)
        ) u_array (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_en   (lk_en_a),
            .lk_kind (lk_k),
            .lk_va   (lk_va),
            .fl_en   (fl_en_a),
            .fl_vpn  (fl_vpn),
            .fl_pte  (fl_pte),
            .inv_en  (inv_valid),
            .inv_set (inv_set),
            .hit_o   (arr_hit[a]),
            .pa_o    (arr_pa[a])
        );
    end

    always_comb begin
        res_d       = '0;
        res_d.valid = lk_valid;
        if (lk_k == KIND_FETCH) begin
            res_d.hit = lk_valid && arr_hit[ARR_INSTR];
            res_d.pa  = res_d.hit ? arr_pa[ARR_INSTR] : '0;
        end else begin
            res_d.hit = lk_valid && arr_hit[ARR_DATA];
            res_d.pa  = res_d.hit ? arr_pa[ARR_DATA] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_pa    = res_q.pa;

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_miss_zero_pa_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_pa == '0));

    assert_hit_needs_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);
endmodule

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [1:0]  lk_kind = 2'd0;
    logic [31:0] lk_va = '0;
    logic        fl_valid = 1'b0;
    logic [1:0]  fl_kind = 2'd0;
    logic [19:0] fl_vpn = '0;
    logic [31:0] fl_pte = '0;
    logic        inv_valid = 1'b0;
    logic [5:0]  inv_set = '0;
    logic        res_valid, res_hit;
    logic [31:0] res_pa;

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2, PR = 2'd3;

    int compared = 0;
    int mismatched = 0;

    logic [32:0] exp_q [$];
    string       req_q [$];

    always #2.5 clk = ~clk;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_va(lk_va),
        .fl_valid(fl_valid), .fl_kind(fl_kind), .fl_vpn(fl_vpn), .fl_pte(fl_pte),
        .inv_valid(inv_valid), .inv_set(inv_set),
        .res_valid(res_valid), .res_hit(res_hit), .res_pa(res_pa)
    );

    // monitor: pops one expected item per result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL unexpected result: actual hit=%0b pa=%h expected none", res_hit, res_pa);
            end else begin
                logic [32:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if ({res_hit, res_pa} !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual hit=%0b pa=%h expected hit=%0b pa=%h",
                             r, res_hit, res_pa, e[32], e[31:0]);
                end
            end
        end
    end

    task automatic step(input bit lv, input logic [1:0] lk, input logic [31:0] va,
                        input bit fv, input logic [1:0] fk, input logic [31:0] fva,
                        input logic [31:0] fpte, input bit iv, input logic [31:0] iva,
                        input bit eh, input logic [31:0] epa, input string req);
        @(negedge clk);
        lk_valid  = lv;  lk_kind = lk;  lk_va = va;
        fl_valid  = fv;  fl_kind = fk;  fl_vpn = fva[31:12]; fl_pte = fpte;
        inv_valid = iv;  inv_set = iva[17:12];
        if (lv) begin
            exp_q.push_back({eh, eh ? epa : 32'h0});
            req_q.push_back(req);
        end
    endtask

    task automatic look(input logic [1:0] k, input logic [31:0] va, input bit eh,
                        input logic [31:0] epa, input string req);
        step(1, k, va, 0, RD, 0, 0, 0, 0, eh, epa, req);
    endtask

    task automatic fill(input logic [1:0] k, input logic [31:0] va, input logic [31:0] pte);
        step(0, RD, 0, 1, k, va, pte, 0, 0, 0, 0, "");
    endtask

    task automatic inval(input logic [31:0] va);
        step(0, RD, 0, 0, RD, 0, 0, 1, va, 0, 0, "");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: outputs cleared under reset
        compared++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_pa !== 32'h0) begin
            mismatched++;
            $display("FAIL R11 reset outputs: actual v=%0b h=%0b pa=%h expected 0 0 0",
                     res_valid, res_hit, res_pa);
        end
        rst_n = 1'b1;

        // R11: entries invalid with zero tag, so page 0 misses
        look(RD, 32'h0000_0123, 0, 0, "R11 zero-tag read after reset");
        look(FE, 32'h0000_0123, 0, 0, "R11 zero-tag fetch after reset");
        look(RD, 32'h0001_2345, 0, 0, "R4 cold miss");

        // R1 R2 R3: data fill then hit; instruction side separate
        fill(RD, 32'h0001_2000, 32'hABCD_E080);
        look(RD, 32'h0001_2345, 1, 32'hABCD_E345, "R2 data hit pa");
        look(RD, 32'h0041_2345, 0, 0, "R1 same set other tag");
        look(FE, 32'h0001_2345, 0, 0, "R3 fetch uses other structure");
        fill(FE, 32'h0001_2000, 32'h1111_1000);
        look(FE, 32'h0001_2345, 1, 32'h1111_1345, "R3 fetch hit");
        look(WR, 32'h0001_2010, 1, 32'hABCD_E010, "R5 write hit changed set");

        // R5: changed bit clear
        fill(WR, 32'h0005_3000, 32'h2222_2000);
        look(RD, 32'h0005_3004, 1, 32'h2222_2004, "R5 read ignores changed bit");
        look(WR, 32'h0005_3004, 0, 0, "R5 write with changed clear misses");
        look(WR, 32'h0005_3004, 1, 32'h2222_2004, "R5 second write hits");

        // R8 R6: replacement in set 2
        fill(RD, 32'h0000_2000, 32'hA000_0080);
        fill(RD, 32'h0004_2000, 32'hB000_0080);
        look(RD, 32'h0000_2010, 1, 32'hA000_0010, "R6 touch A");
        fill(RD, 32'h0008_2000, 32'hC000_0080);
        look(RD, 32'h0004_2010, 0, 0, "R8 B evicted");
        look(RD, 32'h0000_2020, 1, 32'hA000_0020, "R8 A kept");
        look(RD, 32'h0008_2030, 1, 32'hC000_0030, "R6 touch C");
        fill(RD, 32'h0004_2000, 32'hB000_0080);
        look(RD, 32'h0000_2040, 0, 0, "R8 A evicted after C touched");
        look(RD, 32'h0004_2050, 1, 32'hB000_0050, "R8 B refilled");
        look(RD, 32'h0008_2060, 1, 32'hC000_0060, "R8 C kept");

        // R7: probe leaves markers alone
        fill(RD, 32'h0000_3000, 32'hD000_0080);
        fill(RD, 32'h0004_3000, 32'hE000_0080);
        look(PR, 32'h0000_3070, 1, 32'hD000_0070, "R7 probe hit");
        fill(RD, 32'h0008_3000, 32'hF000_0080);
        look(PR, 32'h0000_3070, 0, 0, "R7 probed page evicted");
        look(PR, 32'h0004_3080, 1, 32'hE000_0080, "R7 recent page kept");
        look(PR, 32'h0008_3090, 1, 32'hF000_0090, "R7 new page present");

        // R9: probe fill ignored
        fill(PR, 32'h0000_4000, 32'h5555_5080);
        look(RD, 32'h0000_4000, 0, 0, "R9 probe fill data side");
        look(FE, 32'h0000_4000, 0, 0, "R9 probe fill instr side");

        // R10: invalidate by set, no tag compare
        inval(32'h0009_2000);
        look(RD, 32'h0001_2345, 0, 0, "R10 data side dropped");
        look(FE, 32'h0001_2345, 0, 0, "R10 instr side dropped");
        look(RD, 32'h0005_3008, 1, 32'h2222_2008, "R10 other set kept");

        // R12: same-cycle ordering
        step(1, RD, 32'h0005_3008, 0, RD, 0, 0, 1, 32'h0005_3000, 1, 32'h2222_2008,
             "R12 lookup before invalidate");
        look(RD, 32'h0005_3008, 0, 0, "R12 invalidate applied");
        step(1, RD, 32'h0006_0000, 1, RD, 32'h0006_0000, 32'h3333_3080, 0, 0, 0, 0,
             "R12 lookup before fill");
        look(RD, 32'h0006_0abc, 1, 32'h3333_3abc, "R12 fill applied");
        step(0, RD, 0, 1, RD, 32'h0007_0000, 32'h4444_4080, 1, 32'h0007_0000, 0, 0, "");
        look(RD, 32'h0007_0000, 0, 0, "R12 invalidate wins over fill");

        step(0, RD, 0, 0, RD, 0, 0, 0, 0, 0, 0, "");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL R2 missing results: actual %0d pending expected 0", exp_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule